// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block lives inside an SDRAM controller and owns every refresh-related command on the memory bus. It counts clock cycles since the last row refresh. When a refresh falls due it asks the read/write path for the bus. Once the bus is granted, it closes all banks with a precharge-all command and waits out the precharge recovery time. It then issues AUTO REFRESH and holds the bus idle for the refresh cycle time. If the refresh is left waiting for several intervals, a sticky overdue flag latches.

A low-power request uses the same handshake to place the device in self-refresh. The block precharges all banks and issues the refresh encoding with the clock enable driven low in the same cycle. It keeps the clock enable low for at least the minimum residency, and for as long as the request is held after that. To exit, it raises the clock enable and drives NOP through the exit recovery window, which always lasts at least two cycles. It then returns the bus and restarts refresh pacing from zero. All timing values are parameters in clock cycles: the refresh interval, tRP, tRFC, tRAS and tXSR. The three wait times (tRP, tRFC and tRAS) must each be at least 2.

Top module: `sdram_refresh_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the command is NOP, the clock enable is high, and the request, low-power status, overdue flag and A10 are all low.
- R2: The bus request rises exactly REF_INT cycles after the last AUTO REFRESH, or REF_INT cycles after reset. It stays high until the refresh is granted.
- R3: A grant sampled while a refresh is due produces PRECHARGE with A10 high in the next cycle. AUTO REFRESH follows exactly T_RP cycles after the PRECHARGE, with NOP in the cycles between.
- R4: After AUTO REFRESH, only NOP is driven for T_RFC-1 cycles. The request then drops unless another request is active.
- R5: When a refresh is due and self-refresh is also requested, the AUTO REFRESH sequence completes before self-refresh entry begins.
- R6: Self-refresh entry drives PRECHARGE with A10 high. Exactly T_RP cycles later it drives the AUTO REFRESH encoding with the clock enable low in that same cycle, and the low-power status goes high.
- R7: The clock enable stays low, with NOP on the command bus, for at least T_RAS cycles counted from the entry cycle. It stays low until the low-power request is released.
- R8: When the clock enable rises, NOP is driven for max(2, T_XSR) cycles. Only after that is the bus released.
- R9: After self-refresh exit the refresh interval restarts. The request rises REF_INT cycles after the last exit NOP cycle, that is, REF_INT-1 cycles after the bus is released.
- R10: The overdue flag sets one cycle after REF_INT*OVD_N cycles have passed without an AUTO REFRESH, and stays set until reset.
- R11: A grant while neither refresh nor self-refresh is requested issues no command. The outputs stay NOP with the clock enable high.

Command encoding on cmdOut is {cs_n, ras_n, cas_n, we_n}: NOP = 0111, PRECHARGE = 0010, AUTO REFRESH = 0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refGrant | input | 1 | Bus grant from the read/write arbiter |
| lpReq | input | 1 | Level request to enter and remain in self-refresh |
| refReq | output | 1 | Bus request; high while a sequence is needed or running |
| lpActive | output | 1 | High while the device is in self-refresh (clock enable low) |
| cke | output | 1 | SDRAM clock enable |
| cmdOut | output | 4 | SDRAM command {cs_n, ras_n, cas_n, we_n} |
| a10 | output | 1 | Address bit 10; high during precharge-all |
| overdue | output | 1 | Sticky flag: refresh was not serviced in time |

## Verification
Several properties are checked on every cycle by the assertions. Every PRECHARGE has A10 high. AUTO REFRESH is always preceded by NOP. A refresh with the clock enable high is followed by NOP. The clock enable falls only on the refresh encoding. NOP is driven while the clock enable stays low and in the cycle after it rises. The overdue flag never clears. The exact cycle counts cannot be expressed as simple properties and are left to the bench's reference model, compared every clock: the refresh interval, the tRP, tRFC, tRAS and tXSR windows, the priority of a pending refresh over self-refresh, and the restart of pacing after exit.

// File: rtl/sdr_refresh_pkg.sv
package sdr_refresh_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_RPWAIT,
    ST_AREF,
    ST_RFCWAIT,
    ST_SPRE,
    ST_SRPWAIT,
    ST_SENTER,
    ST_SHOLD,
    ST_SEXIT
  } seqState_t;

  typedef struct packed {
    logic rldInt;
    logic ldRp;
    logic ldRfc;
    logic ldRas;
    logic ldXsr;
    logic dec;
  } seqStrobe_t;

  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_refresh_dp.sv
module sdr_refresh_dp
  import sdr_refresh_pkg::*;
#(
  parameter int REF_INT = 1039,
  parameter int T_RP    = 3,
  parameter int T_RFC   = 9,
  parameter int T_RAS   = 6,
  parameter int T_XSR   = 10,
  parameter int OVD_N   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t stb,
  output logic       refDue,
  output logic       waitZero,
  output logic       overdue
);

  localparam int LIM     = REF_INT * OVD_N;
  localparam int CW      = $clog2(LIM + 1);
  localparam int XSR_EFF = (T_XSR < 2) ? 2 : T_XSR;
  localparam int WMAX    = maxOf(maxOf(T_RP - 2, T_RFC - 2), maxOf(T_RAS - 2, XSR_EFF - 1));
  localparam int WW      = $clog2(WMAX + 2);

  localparam logic [CW-1:0] LIM_V = CW'(LIM);
  localparam logic [CW-1:0] INT_V = CW'(REF_INT);
  localparam logic [CW-1:0] ONE_V = CW'(1);
  localparam logic [WW-1:0] RP_V  = WW'(T_RP - 2);
  localparam logic [WW-1:0] RFC_V = WW'(T_RFC - 2);
  localparam logic [WW-1:0] RAS_V = WW'(T_RAS - 2);
  localparam logic [WW-1:0] XSR_V = WW'(XSR_EFF - 1);
  localparam logic [WW-1:0] W1_V  = WW'(1);

  logic [CW-1:0] age;
  logic [WW-1:0] waitCnt;

  // cycles since the last refresh, saturating at the overdue limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            age <= '0;
    else if (stb.rldInt)  age <= ONE_V;
    else if (age != LIM_V) age <= age + ONE_V;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              overdue <= 1'b0;
    else if (age == LIM_V)  overdue <= 1'b1;
  end

  // shared countdown for the tRP, tRFC, tRAS and tXSR windows
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         waitCnt <= '0;
    else if (stb.ldRp)                 waitCnt <= RP_V;
    else if (stb.ldRfc)                waitCnt <= RFC_V;
    else if (stb.ldRas)                waitCnt <= RAS_V;
    else if (stb.ldXsr)                waitCnt <= XSR_V;
    else if (stb.dec && waitCnt != '0) waitCnt <= waitCnt - W1_V;
  end

  assign refDue   = (age >= INT_V);
  assign waitZero = (waitCnt == '0);

  AST_OVD_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(overdue) |-> overdue); // R10

endmodule

// File: rtl/sdr_refresh_ctrl.sv
module sdr_refresh_ctrl
  import sdr_refresh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refGrant,
  input  logic       lpReq,
  input  logic       refDue,
  input  logic       waitZero,
  output seqState_t  state,
  output seqStrobe_t stb
);

  seqState_t nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt = state;
    stb = '0;
    case (state)
      ST_IDLE: begin
        if (refGrant && refDue)      nxt = ST_PRE;
        else if (refGrant && lpReq)  nxt = ST_SPRE;
      end
      ST_PRE: begin
        stb.ldRp = 1'b1;
        nxt = ST_RPWAIT;
      end
      ST_RPWAIT: begin
        stb.dec = 1'b1;
        if (waitZero) nxt = ST_AREF;
      end
      ST_AREF: begin
        stb.rldInt = 1'b1;
        stb.ldRfc  = 1'b1;
        nxt = ST_RFCWAIT;
      end
      ST_RFCWAIT: begin
        stb.dec = 1'b1;
        if (waitZero) nxt = ST_IDLE;
      end
      ST_SPRE: begin
        stb.ldRp = 1'b1;
        nxt = ST_SRPWAIT;
      end
      ST_SRPWAIT: begin
        stb.dec = 1'b1;
        if (waitZero) nxt = ST_SENTER;
      end
      ST_SENTER: begin
        stb.rldInt = 1'b1;
        stb.ldRas  = 1'b1;
        nxt = ST_SHOLD;
      end
      ST_SHOLD: begin
        stb.rldInt = 1'b1;
        stb.dec    = 1'b1;
        if (waitZero && !lpReq) begin
          stb.ldXsr = 1'b1;
          nxt = ST_SEXIT;
        end
      end
      ST_SEXIT: begin
        stb.rldInt = 1'b1;
        stb.dec    = 1'b1;
        if (waitZero) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
  import sdr_refresh_pkg::*;
#(
  parameter int REF_INT = 1039,
  parameter int T_RP    = 3,
  parameter int T_RFC   = 9,
  parameter int T_RAS   = 6,
  parameter int T_XSR   = 10,
  parameter int OVD_N   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refGrant,
  input  logic       lpReq,
  output logic       refReq,
  output logic       lpActive,
  output logic       cke,
  output logic [3:0] cmdOut,
  output logic       a10,
  output logic       overdue
);

  seqState_t  state;
  seqStrobe_t stb;
  logic       refDue;
  logic       waitZero;

  sdr_refresh_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .refGrant (refGrant),
    .lpReq    (lpReq),
    .refDue   (refDue),
    .waitZero (waitZero),
    .state    (state),
    .stb      (stb)
  );

  sdr_refresh_dp #(
    .REF_INT (REF_INT),
    .T_RP    (T_RP),
    .T_RFC   (T_RFC),
    .T_RAS   (T_RAS),
    .T_XSR   (T_XSR),
    .OVD_N   (OVD_N)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .refDue   (refDue),
    .waitZero (waitZero),
    .overdue  (overdue)
  );

  always_comb begin
    cmdOut = CMD_NOP;
    a10    = 1'b0;
    case (state)
      ST_PRE, ST_SPRE: begin
        cmdOut = CMD_PRE;
        a10    = 1'b1;
      end
      ST_AREF, ST_SENTER: cmdOut = CMD_REF;
      default: cmdOut = CMD_NOP;
    endcase
  end

  assign cke      = !(state == ST_SENTER || state == ST_SHOLD);
  assign lpActive = (state == ST_SENTER || state == ST_SHOLD);
  assign refReq   = (state != ST_IDLE) || refDue || lpReq;

  AST_PRE_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == CMD_PRE) |-> a10); // R3
  AST_REF_AFTER_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == CMD_REF) |-> ($past(cmdOut) == CMD_NOP)); // R3
  AST_RFC_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == CMD_REF && cke) |=> (cmdOut == CMD_NOP)); // R4
  AST_CKE_FALL_ON_REF: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cke) |-> (cmdOut == CMD_REF)); // R6
  AST_SR_HOLD_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (!cke && $past(!cke)) |-> (cmdOut == CMD_NOP)); // R7
  AST_EXIT_NOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> (cmdOut == CMD_NOP)); // R8
  AST_EXIT_NOP_TWO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |=> (cmdOut == CMD_NOP)); // R8

endmodule

// File: tb/sim_sdram_refresh_seq.sv
module sim_sdram_refresh_seq;

  localparam int RI    = 40;
  localparam int TRP   = 3;
  localparam int TRFC  = 7;
  localparam int TRAS  = 6;
  localparam int TXSR  = 9;
  localparam int ON    = 3;
  localparam int LIM   = RI * ON;
  localparam int XEFF  = (TXSR < 2) ? 2 : TXSR;

  logic       clk = 1'b0;
  logic       rstN;
  logic       refGrant;
  logic       lpReq;
  logic       refReq, lpActive, cke, a10, overdue;
  logic [3:0] cmdOut;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sdram_refresh_seq #(
    .REF_INT (RI), .T_RP (TRP), .T_RFC (TRFC),
    .T_RAS (TRAS), .T_XSR (TXSR), .OVD_N (ON)
  ) u0 (
    .clk (clk), .rstN (rstN), .refGrant (refGrant), .lpReq (lpReq),
    .refReq (refReq), .lpActive (lpActive), .cke (cke),
    .cmdOut (cmdOut), .a10 (a10), .overdue (overdue)
  );

  // reference model: phase, cycles left in phase, age since refresh
  // phases: 0 idle 1 pre 2 rp-wait 3 aref 4 rfc-wait
  //         5 sr-pre 6 sr-rp-wait 7 sr-enter 8 sr-hold 9 sr-exit
  int mPh   = 0;
  int mLeft = 0;
  int mAge  = 0;
  bit mOvd  = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mLeft = 0; mAge = 0; mOvd = 1'b0;
    end else begin
      bit due;
      due = (mAge >= RI);
      if (mAge == LIM) mOvd = 1'b1;
      if (mPh == 3 || mPh == 7 || mPh == 8 || mPh == 9) mAge = 1;
      else if (mAge < LIM) mAge = mAge + 1;
      case (mPh)
        0: if (refGrant && due) mPh = 1;
           else if (refGrant && lpReq) mPh = 5;
        1: begin mPh = 2; mLeft = TRP - 1; end
        2: if (mLeft == 1) mPh = 3; else mLeft = mLeft - 1;
        3: begin mPh = 4; mLeft = TRFC - 1; end
        4: if (mLeft == 1) mPh = 0; else mLeft = mLeft - 1;
        5: begin mPh = 6; mLeft = TRP - 1; end
        6: if (mLeft == 1) mPh = 7; else mLeft = mLeft - 1;
        7: begin mPh = 8; mLeft = TRAS - 1; end
        8: if (mLeft > 1) mLeft = mLeft - 1;
           else if (!lpReq) begin mPh = 9; mLeft = XEFF; end
        9: if (mLeft == 1) mPh = 0; else mLeft = mLeft - 1;
        default: mPh = 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison, sampled on the falling edge
  always @(negedge clk) begin
    if (!done) begin
      logic [3:0] eCmd;
      logic [8:0] got, exp;
      string tag;
      eCmd = (mPh == 1 || mPh == 5) ? 4'b0010 :
             (mPh == 3 || mPh == 7) ? 4'b0001 : 4'b0111;
      exp = {eCmd, (mPh == 1 || mPh == 5), !(mPh == 7 || mPh == 8),
             (mPh != 0) || (mAge >= RI) || lpReq, (mPh == 7 || mPh == 8), mOvd};
      got = {cmdOut, a10, cke, refReq, lpActive, overdue};
      if (!rstN)                   tag = "R1";
      else if (got[0] != exp[0])   tag = "R10";
      else case (mPh)
        0:       tag = (got[8:5] != exp[8:5]) ? "R11" : "R2";
        1, 2, 3: tag = "R3";
        4:       tag = "R4";
        5, 6, 7: tag = "R6";
        8:       tag = "R7";
        default: tag = "R8";
      endcase
      chk(got === exp, tag, int'(got), int'(exp));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    int arCnt;
    int lowCnt;
    rstN = 1'b0; refGrant = 1'b0; lpReq = 1'b0;
    step(4);
    rstN = 1'b1;
    // R1 first cycle after reset
    @(negedge clk);
    chk(cmdOut == 4'b0111 && cke && !refReq && !overdue, "R1", int'(cmdOut), 7);
    step(1);
    // R2/R3/R4: grant held, periodic refreshes
    refGrant = 1'b1;
    step(150);
    // R10: starve the refresh past the overdue limit
    refGrant = 1'b0;
    step(150);
    chk(overdue == 1'b1, "R10", int'(overdue), 1);
    refGrant = 1'b1;
    step(30);
    chk(overdue == 1'b1, "R10", int'(overdue), 1);
    // R5: refresh due and self-refresh requested together
    refGrant = 1'b0;
    step(45);
    lpReq = 1'b1; refGrant = 1'b1; arCnt = 0;
    for (int k = 0; k < 200 && !lpActive; k++) begin
      @(negedge clk);
      if (cmdOut == 4'b0001 && cke) arCnt++;
    end
    chk(arCnt >= 1, "R5", arCnt, 1);
    step(20);
    lpReq = 1'b0; refGrant = 1'b0;
    // R9: interval restart after exit
    for (int k = 0; k < 200 && !cke; k++) @(negedge clk);
    for (int k = 0; k < 200 && refReq; k++) @(negedge clk);
    lowCnt = 0;
    while (!refReq && lowCnt < 200) begin
      lowCnt++;
      @(negedge clk);
    end
    chk(lowCnt == RI - 1, "R9", lowCnt, RI - 1);
    @(posedge clk); #2;
    // R7: request released as soon as entry is seen
    refGrant = 1'b1; lpReq = 1'b1;
    for (int k = 0; k < 300 && !lpActive; k++) @(negedge clk);
    @(posedge clk); #2;
    lpReq = 1'b0;
    step(40);
    // R11: grant with nothing to do
    step(20);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R1 act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule